// File: doc/BRIEF.md
# Counter Clock and Gate Router

This block holds three 16-bit down-counters and decides, for each of them, which signal clocks it and which signal gates it. A counter can be clocked by a shared internal timebase, by its own external clock pin, or by the terminal state of the counter before it in a ring of three. Each counter decrements once per selected clock edge while its gate is active, and it stops at zero. Pins are synchronised to the system clock, and counting happens on one-cycle enables taken from the chosen edge.

A counter whose gate mode is set to measurement joins a pulse-width measurement. An arm strobe reloads all such counters to 0xFFFF and starts a small state machine on a shared measured input. The machine waits for a rising edge, then follows one high phase and one low phase. A counter with gate polarity 0 counts during the high phase, and one with polarity 1 counts during the low phase. Software reads each phase length as 65535 minus the final count. A status bit shows that a measurement is still in progress.

Software reaches all state through a small register port. Writes take effect on the clock edge at which they are presented. Reads return data one cycle after the address is presented.

Top module: `ctr_router_top`

## Requirements
- R1: After reset every count reads 0xFFFF, every control word reads 0, the timebase select reads 0 and every `ctr_out` bit is 0.
- R2: A write to address 4+i loads counter i with `wr_data`. A read of address 4+i returns the count one cycle later. With clock source code 11 the counter holds its value.
- R3: With clock source code 01 a counter decrements by one per edge of its synchronised external clock pin. Control bit 2 (the edge bit) selects rising edges when 0 and falling edges when 1.
- R4: A counter at zero stays at zero until reloaded. `ctr_out[i]` is 1 one cycle after counter i reaches zero.
- R5: With clock source code 00 a counter decrements once every TB_DIV0·10^s system cycles. Here s is the 2-bit timebase select in bits 1:0 of address 7.
- R6: Gate source code 00 always enables counting. Code 10 enables counting from the synchronised external gate pin, which counts when high if control bit 5 is 0 and when low if control bit 5 is 1. An inactive gate freezes the count.
- R7: Clock source code 10 and gate source code 01 both take the zero flag of the previous counter in the ring: counter 0 from 2, 1 from 0, and 2 from 1.
- R8: Control word layout: bits 1:0 clock source, bit 2 edge, bits 4:3 gate source, bit 5 gate polarity. Reads return these bits, with bit 15 as the measurement status.
- R9: Writing address 7 with bit 8 set arms a measurement. Every counter in gate mode 11 is reloaded to 0xFFFF and its status bit reads 1. The status clears after a rising edge, a full high phase, a full low phase and the next rising edge of `meas_in`. Any later activity on `meas_in` leaves the counts unchanged.
- R10: During a measurement, a gate-mode-11 counter with polarity 0 counts only in the high phase, and one with polarity 1 counts only in the low phase. For each phase, 65535 minus the final count equals the number of timebase ticks in that phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 16 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 16 | Registered read data |
| ext_clk | input | 3 | External clock pin per counter |
| ext_gate | input | 3 | External gate pin per counter |
| meas_in | input | 1 | Signal under pulse-width measurement |
| ctr_out | output | 3 | Registered zero flag per counter |

## Verification
The embedded properties check on every cycle that:
- a count never moves by more than one step without a load;
- a count holds at zero and freezes under a closed gate;
- the timebase enable is a single-cycle pulse;
- the measurement machine reaches its finished state only from the low phase;
- arming reloads the measurement counters.

Only the bench scenarios can show the true tick rate at each timebase setting, the choice between rising and falling edges, and the routing of the ring. They also show the exact phase lengths that come out of a measurement, and that the counts stay frozen once a measurement has finished.

// File: rtl/ctr_pkg.sv
package ctr_pkg;
  typedef enum logic [1:0] {
    CS_TIMEBASE = 2'b00,
    CS_PIN      = 2'b01,
    CS_CHAIN    = 2'b10,
    CS_OFF      = 2'b11
  } clk_src_e;

  typedef enum logic [1:0] {
    GS_ON    = 2'b00,
    GS_CHAIN = 2'b01,
    GS_PIN   = 2'b10,
    GS_MEAS  = 2'b11
  } gate_src_e;

  typedef struct packed {
    logic      gate_pol;
    gate_src_e gate_src;
    logic      clk_edge;
    clk_src_e  clk_src;
  } ctr_ctrl_t;

  typedef enum logic [2:0] {
    PW_IDLE,
    PW_WAIT,
    PW_HIGH,
    PW_LOW,
    PW_DONE
  } pw_state_e;

  localparam int CTRL_W = $bits(ctr_ctrl_t);
endpackage

// File: rtl/ctr_timebase.sv
module ctr_timebase #(
  parameter int DIV0   = 20,
  parameter int STAGES = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] sel,
  output logic       tb_clk
);
  localparam int W0 = (DIV0 > 1) ? $clog2(DIV0) : 1;

  logic [W0-1:0]     pre_q;
  logic [STAGES-1:0] pulse;

  always_ff @(posedge clk) begin
    if (rst) pre_q <= '0;
    else if (pre_q == W0'(DIV0 - 1)) pre_q <= '0;
    else pre_q <= pre_q + 1'b1;
  end
  assign pulse[0] = (pre_q == W0'(DIV0 - 1));

  for (genvar g = 1; g < STAGES; g++) begin : g_decade
    logic [3:0] dec_q;
    always_ff @(posedge clk) begin
      if (rst) dec_q <= '0;
      else if (pulse[g-1]) dec_q <= (dec_q == 4'd9) ? 4'd0 : dec_q + 4'd1;
    end
    assign pulse[g] = pulse[g-1] && (dec_q == 4'd9);
  end

  always_ff @(posedge clk) begin
    if (rst) tb_clk <= 1'b0;
    else     tb_clk <= pulse[sel];
  end

  // R5: the timebase enable is a single-cycle pulse
  assert_tick_single_R5: assert property (@(posedge clk) disable iff (rst)
    tb_clk |=> !tb_clk);
endmodule

// File: rtl/ctr_pw_fsm.sv
module ctr_pw_fsm
  import ctr_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic arm,
  input  logic meas_pin,
  output logic meas_high,
  output logic meas_low,
  output logic busy
);
  logic [2:0] sync_q;
  pw_state_e  state_q;
  logic       rise, fall;

  always_ff @(posedge clk) begin
    if (rst) sync_q <= '0;
    else     sync_q <= {sync_q[1:0], meas_pin};
  end
  assign rise = sync_q[1] & ~sync_q[2];
  assign fall = ~sync_q[1] & sync_q[2];

  always_ff @(posedge clk) begin
    if (rst) state_q <= PW_IDLE;
    else if (arm) state_q <= PW_WAIT;
    else begin
      case (state_q)
        PW_WAIT: if (rise) state_q <= PW_HIGH;
        PW_HIGH: if (fall) state_q <= PW_LOW;
        PW_LOW:  if (rise) state_q <= PW_DONE;
        default: state_q <= state_q;
      endcase
    end
  end

  assign meas_high = (state_q == PW_HIGH);
  assign meas_low  = (state_q == PW_LOW);
  assign busy      = (state_q == PW_WAIT) || meas_high || meas_low;

  // R9: completion is reached only at the end of a low phase
  assert_done_from_low_R9: assert property (@(posedge clk) disable iff (rst)
    (state_q == PW_DONE) |-> ($past(state_q) == PW_LOW || $past(state_q) == PW_DONE));
  // R9: arming always restarts the wait for a rising edge
  assert_arm_waits_R9: assert property (@(posedge clk) disable iff (rst)
    arm |=> (state_q == PW_WAIT));
endmodule

// File: rtl/ctr_channel.sv
module ctr_channel
  import ctr_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  ctr_ctrl_t     ctrl,
  input  logic          tb_clk,
  input  logic          pin_clk,
  input  logic          pin_gate,
  input  logic          chain_zero,
  input  logic          meas_high,
  input  logic          meas_low,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          reload,
  output logic [CW-1:0] count,
  output logic          zero,
  output logic          out_q
);
  logic [1:0]    clk_sync_q, gate_sync_q;
  logic          sel_clk, prev_clk_q, tick, gate_ok;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      clk_sync_q  <= '0;
      gate_sync_q <= '0;
    end else begin
      clk_sync_q  <= {clk_sync_q[0], pin_clk};
      gate_sync_q <= {gate_sync_q[0], pin_gate};
    end
  end

  always_comb begin
    case (ctrl.clk_src)
      CS_TIMEBASE: sel_clk = tb_clk;
      CS_PIN:      sel_clk = clk_sync_q[1];
      CS_CHAIN:    sel_clk = chain_zero;
      default:     sel_clk = prev_clk_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) prev_clk_q <= 1'b0;
    else     prev_clk_q <= sel_clk;
  end
  assign tick = ctrl.clk_edge ? (prev_clk_q & ~sel_clk) : (sel_clk & ~prev_clk_q);

  always_comb begin
    case (ctrl.gate_src)
      GS_ON:    gate_ok = 1'b1;
      GS_CHAIN: gate_ok = chain_zero ^ ctrl.gate_pol;
      GS_PIN:   gate_ok = gate_sync_q[1] ^ ctrl.gate_pol;
      default:  gate_ok = ctrl.gate_pol ? meas_low : meas_high;
    endcase
  end

  assign zero = (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '1;
    else if (load) cnt_q <= load_val;
    else if (reload) cnt_q <= '1;
    else if (tick && gate_ok && !zero) cnt_q <= cnt_q - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) out_q <= 1'b0;
    else     out_q <= zero;
  end

  assign count = cnt_q;

  // R4: a count at zero stays there until reloaded
  assert_hold_zero_R4: assert property (@(posedge clk) disable iff (rst)
    (zero && !load && !reload) |=> (cnt_q == '0));
  // R3: without a load the count moves down by at most one per cycle
  assert_single_step_R3: assert property (@(posedge clk) disable iff (rst)
    (!load && !reload) |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) - 1'b1));
  // R6: a closed gate freezes the count
  assert_gate_freeze_R6: assert property (@(posedge clk) disable iff (rst)
    (!load && !reload && !gate_ok) |=> $stable(cnt_q));
endmodule

// File: rtl/ctr_router_top.sv
module ctr_router_top
  import ctr_pkg::*;
#(
  parameter int NUM_CTR = 3,
  parameter int CW      = 16,
  parameter int AW      = 3,
  parameter int TB_DIV0 = 20
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wr_en,
  input  logic [AW-1:0]  wr_addr,
  input  logic [CW-1:0]  wr_data,
  input  logic [AW-1:0]  rd_addr,
  output logic [CW-1:0]  rd_data,
  input  logic [NUM_CTR-1:0] ext_clk,
  input  logic [NUM_CTR-1:0] ext_gate,
  input  logic           meas_in,
  output logic [NUM_CTR-1:0] ctr_out
);
  localparam int CNT_BASE = 4;
  localparam int GLB_ADDR = 7;
  localparam int ARM_BIT  = 8;

  ctr_ctrl_t          ctrl_q [NUM_CTR];
  logic [1:0]         tb_sel_q;
  logic               tb_clk, arm, meas_high, meas_low, meas_busy;
  logic [CW-1:0]      count_w [NUM_CTR];
  logic [NUM_CTR-1:0] zero_w, load_w, reload_w;

  assign arm = wr_en && (wr_addr == AW'(GLB_ADDR)) && wr_data[ARM_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      tb_sel_q <= '0;
      for (int i = 0; i < NUM_CTR; i++) ctrl_q[i] <= '0;
    end else if (wr_en) begin
      if (wr_addr == AW'(GLB_ADDR)) tb_sel_q <= wr_data[1:0];
      for (int i = 0; i < NUM_CTR; i++)
        if (wr_addr == AW'(i)) ctrl_q[i] <= ctr_ctrl_t'(wr_data[CTRL_W-1:0]);
    end
  end

  ctr_timebase #(.DIV0(TB_DIV0)) u_tb (
    .clk(clk), .rst(rst), .sel(tb_sel_q), .tb_clk(tb_clk)
  );

  ctr_pw_fsm u_pw (
    .clk(clk), .rst(rst), .arm(arm), .meas_pin(meas_in),
    .meas_high(meas_high), .meas_low(meas_low), .busy(meas_busy)
  );

  for (genvar g = 0; g < NUM_CTR; g++) begin : g_ctr
    localparam int PREV = (g + NUM_CTR - 1) % NUM_CTR;
    assign load_w[g]   = wr_en && (wr_addr == AW'(CNT_BASE + g));
    assign reload_w[g] = arm && (ctrl_q[g].gate_src == GS_MEAS);

    ctr_channel #(.CW(CW)) u_ch (
      .clk(clk), .rst(rst), .ctrl(ctrl_q[g]), .tb_clk(tb_clk),
      .pin_clk(ext_clk[g]), .pin_gate(ext_gate[g]), .chain_zero(zero_w[PREV]),
      .meas_high(meas_high), .meas_low(meas_low),
      .load(load_w[g]), .load_val(wr_data), .reload(reload_w[g]),
      .count(count_w[g]), .zero(zero_w[g]), .out_q(ctr_out[g])
    );

    // R9: arming reloads a measurement counter to full scale
    assert_arm_reload_R9: assert property (@(posedge clk) disable iff (rst)
      (reload_w[g] && !load_w[g]) |=> (count_w[g] == '1));
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else begin
      rd_data <= '0;
      if (rd_addr == AW'(GLB_ADDR)) rd_data[1:0] <= tb_sel_q;
      for (int i = 0; i < NUM_CTR; i++) begin
        if (rd_addr == AW'(i)) begin
          rd_data[CTRL_W-1:0] <= ctrl_q[i];
          rd_data[CW-1] <= meas_busy && (ctrl_q[i].gate_src == GS_MEAS);
        end
        if (rd_addr == AW'(CNT_BASE + i)) rd_data <= count_w[i];
      end
    end
  end
endmodule

// File: tb/sim_ctr_router_top.sv
module sim_ctr_router_top;
  localparam int DIV0 = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic [2:0]  ext_clk = '0;
  logic [2:0]  ext_gate = '0;
  logic        meas_in = 1'b0;
  logic [2:0]  ctr_out;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ctr_router_top #(.TB_DIV0(DIV0)) u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .ext_clk(ext_clk), .ext_gate(ext_gate),
    .meas_in(meas_in), .ctr_out(ctr_out)
  );

  // {edge[10], sel[9:8], ticks[7:0]}
  localparam logic [10:0] VEC [5] = '{
    {1'b0, 2'd0, 8'd25},
    {1'b1, 2'd0, 8'd9},
    {1'b0, 2'd1, 8'd7},
    {1'b1, 2'd2, 8'd3},
    {1'b0, 2'd3, 8'd2}
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    rd_addr = a;
    @(negedge clk);
    d = rd_data;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic burst(input int idx);
    for (int p = 0; p < 5; p++) begin
      ext_clk[idx] = 1'b1; idle(4);
      ext_clk[idx] = 1'b0; idle(4);
    end
    ext_clk[idx] = 1'b1; idle(6);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    idle(3);
    rst = 1'b0;
    idle(1);
    // R1 reset state
    rd(3'd4, v); check("R1 count0", v, 16'hFFFF);
    rd(3'd6, v); check("R1 count2", v, 16'hFFFF);
    rd(3'd1, v); check("R1 ctrl1", v, 16'h0000);
    rd(3'd7, v); check("R1 tbsel", v, 16'h0000);
    check("R1 ctr_out", {13'd0, ctr_out}, 16'h0000);

    // R2 load and hold with clock source off
    wr(3'd0, 16'h0003);
    wr(3'd4, 16'd1234);
    idle(50);
    rd(3'd4, v); check("R2 load hold", v, 16'd1234);
    rd(3'd0, v); check("R8 ctrl readback", v, 16'h0003);

    // R5 timebase rates: table walk
    for (int i = 0; i < 5; i++) begin
      int per;
      int k;
      per = DIV0;
      for (int s = 0; s < int'(VEC[i][9:8]); s++) per = per * 10;
      k = int'(VEC[i][7:0]);
      wr(3'd7, {14'd0, VEC[i][9:8]});
      wr(3'd0, {13'd0, VEC[i][10], 2'b00});
      idle(4);
      wr(3'd4, 16'd1000);
      idle(k * per);
      rd(3'd4, v);
      check($sformatf("R5 vec%0d", i), v, 16'(1000 - k));
    end
    wr(3'd7, 16'h0000);

    // R3 external clock rising and falling edges
    wr(3'd1, 16'h0001);
    wr(3'd5, 16'd50);
    burst(1);
    rd(3'd5, v); check("R3 rising", v, 16'd44);
    ext_clk[1] = 1'b0; idle(6);
    wr(3'd1, 16'h0005);
    wr(3'd5, 16'd50);
    burst(1);
    rd(3'd5, v); check("R3 falling", v, 16'd45);
    ext_clk[1] = 1'b0; idle(6);

    // R4 stop at zero
    wr(3'd1, 16'h0001);
    wr(3'd5, 16'd3);
    burst(1);
    rd(3'd5, v); check("R4 hold zero", v, 16'd0);
    check("R4 ctr_out", {15'd0, ctr_out[1]}, 16'd1);
    ext_clk[1] = 1'b0; idle(6);

    // R6 external gate with polarity
    wr(3'd2, 16'h0010);
    wr(3'd6, 16'd500);
    idle(100);
    rd(3'd6, v); check("R6 gate closed", v, 16'd500);
    wr(3'd2, 16'h0030);
    idle(4);
    wr(3'd6, 16'd500);
    idle(100);
    rd(3'd6, v); check("R6 gate low active", v, 16'd475);

    // R7 ring chaining of clock and gate
    wr(3'd0, 16'h0001);
    wr(3'd4, 16'd2);
    wr(3'd1, 16'h0002);
    idle(4);
    wr(3'd5, 16'd10);
    burst(0);
    rd(3'd5, v); check("R7 clock chain", v, 16'd9);
    wr(3'd2, 16'h0008);
    wr(3'd6, 16'd300);
    idle(40);
    rd(3'd6, v); check("R7 gate chain closed", v, 16'd300);
    wr(3'd5, 16'd0);
    idle(2);
    wr(3'd6, 16'd300);
    idle(40);
    rd(3'd6, v); check("R7 gate chain open", v, 16'd290);
    ext_clk[0] = 1'b0; idle(6);

    // R9 / R10 pulse-width measurement
    wr(3'd1, 16'h0018);
    wr(3'd2, 16'h0038);
    wr(3'd7, 16'h0100);
    rd(3'd1, v); check("R9 busy set", {15'd0, v[15]}, 16'd1);
    rd(3'd5, v); check("R9 reload", v, 16'hFFFF);
    idle(20);
    meas_in = 1'b1; idle(80);
    meas_in = 1'b0; idle(120);
    meas_in = 1'b1; idle(40);
    rd(3'd2, v); check("R9 busy clear", {15'd0, v[15]}, 16'd0);
    rd(3'd5, v); check("R10 high phase", 16'(16'hFFFF - v), 16'd20);
    rd(3'd6, v); check("R10 low phase", 16'(16'hFFFF - v), 16'd30);
    meas_in = 1'b0; idle(40);
    meas_in = 1'b1; idle(40);
    rd(3'd5, v); check("R9 ignore after done", v, 16'd65515);
    rd(3'd6, v); check("R9 ignore after done low", v, 16'd65505);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule